// File: doc/BRIEF.md
# Full-Duplex SPI Byte Stream Target

This block lets a host exchange two byte streams with the chip over a four-wire SPI link in which it acts only as the target. The block has no registers and no address phase. Every byte the host clocks in on MOSI goes to an inbound stream. In the same eight clocks, the next byte of an outbound stream goes out on MISO. When the outbound stream has nothing pending, the block sends 0xFF, with every bit high. A host with nothing to send holds MOSI high, so its bytes arrive as 0xFF.

Long runs of that filler would flood the inbound side, so the block counts consecutive inbound 0xFF bytes. It passes the first 50 of a run, because such bytes can belong to a real message. It drops the rest of the run until a byte other than 0xFF arrives. The SPI pins are sampled by the block's own clock through two-flop synchronizers, so SCLK must be several times slower than that clock.

Both streams use valid/ready handshakes. On the outbound side the block reads from a FIFO. Once `out_valid` is high, `out_data` must hold steady until `out_ready` accepts it. On the inbound side the block writes to a FIFO and holds `in_valid` and `in_data` until `in_ready` is seen. The inbound side keeps only one byte in reserve. If a new byte completes while that byte is still unaccepted, the new byte is lost.

Top module: `spi_stream_port`

## Requirements
- R1: After reset, MISO is high, `in_valid` is low and `out_ready` is low.
- R2: SPI mode 0 is used: MOSI is sampled on the rising SCLK edge while CS is low, MSB first. Each completed 8-bit byte is offered on `in_data` with `in_valid`.
- R3: The pending outbound byte appears on MISO MSB first. The first bit is driven before the first rising edge of the byte, and each later bit follows a falling edge. `out_ready` pulses for one cycle shortly after the byte's first rising edge.
- R4: If `out_valid` is low when a byte slot is loaded, MISO sends 0xFF for that byte and nothing is popped.
- R5: While CS is high, MISO is high. Deasserting CS clears the bit position, and a partly shifted inbound byte is discarded without being offered.
- R6: If CS rises after the first rising edge of a byte, the outbound byte already popped for it is lost. If CS rises before that edge, nothing is popped and the same byte is sent in the next transfer.
- R7: In a run of consecutive inbound 0xFF bytes, the first 50 are forwarded and every further 0xFF is dropped.
- R8: The first inbound byte other than 0xFF after a run is forwarded and restarts the run count, so later 0xFF bytes are forwarded again.
- R9: The 0xFF run count is kept across CS deassertion; only a byte other than 0xFF or reset clears it.
- R10: `in_valid` and `in_data` stay unchanged until `in_ready` is high. A byte that completes while an earlier byte is still waiting is dropped.
- R11: `out_ready` is only raised while `out_valid` is high, at most once per transferred byte, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, several times faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from host, idle low |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Target-to-host serial data, high when idle |
| out_valid | input | 1 | Outbound FIFO has a byte |
| out_data | input | 8 | Outbound byte, stable while valid |
| out_ready | output | 1 | Pop strobe for the outbound FIFO |
| in_valid | output | 1 | Inbound byte available |
| in_data | output | 8 | Inbound byte |
| in_ready | input | 1 | Inbound FIFO accepts the byte |

## Verification
The assertions check the following on every cycle:
- Pops only happen against a valid outbound byte and never come back to back.
- A waiting inbound byte stays stable until it is accepted.
- The filler-run counter never passes its limit.
- No 0xFF is forwarded once the limit is reached.

Only the bench scenarios can show the bit order on both wires and the 0xFF padding when the outbound stream is empty. The same applies to which outbound byte an aborted transfer consumes, the exact 50-byte cut-off, the count surviving a CS gap, and the byte lost under back-pressure.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t FILL_BYTE = 8'hFF;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_o <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
    end
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_stream_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_s,
  input  logic  mosi_s,
  input  logic  cs_n_s,
  input  logic  out_valid,
  input  byte_t out_data,
  output logic  out_ready,
  output logic  miso,
  output logic  rx_valid,
  output byte_t rx_byte
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic             sclk_d, cs_act_d;
  logic [CNT_W-1:0] bit_pos;
  logic [6:0]       rx_sr;
  byte_t            tx_sr;
  logic             tx_owned;

  logic cs_act, sclk_rise, sclk_fall, cs_start;
  assign cs_act    = !cs_n_s;
  assign sclk_rise = cs_act && sclk_s && !sclk_d;
  assign sclk_fall = cs_act && !sclk_s && sclk_d;
  assign cs_start  = cs_act && !cs_act_d;
  assign miso      = cs_act ? tx_sr[7] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      cs_act_d  <= 1'b0;
      bit_pos   <= '0;
      rx_sr     <= '0;
      tx_sr     <= FILL_BYTE;
      tx_owned  <= 1'b0;
      out_ready <= 1'b0;
      rx_valid  <= 1'b0;
      rx_byte   <= '0;
    end else begin
      sclk_d    <= sclk_s;
      cs_act_d  <= cs_act;
      out_ready <= 1'b0;
      rx_valid  <= 1'b0;
      if (!cs_act) begin
        bit_pos  <= '0;
        tx_sr    <= FILL_BYTE;
        tx_owned <= 1'b0;
      end else if (cs_start) begin
        tx_sr    <= out_valid ? out_data : FILL_BYTE;
        tx_owned <= out_valid;
      end else begin
        if (sclk_rise) begin
          rx_sr   <= {rx_sr[5:0], mosi_s};
          bit_pos <= bit_pos + 1'b1;
          if (bit_pos == LAST_BIT) begin
            rx_valid <= 1'b1;
            rx_byte  <= {rx_sr, mosi_s};
          end
          if (bit_pos == '0 && tx_owned) begin
            out_ready <= 1'b1;
            tx_owned  <= 1'b0;
          end
        end
        if (sclk_fall) begin
          if (bit_pos == '0) begin
            tx_sr    <= out_valid ? out_data : FILL_BYTE;
            tx_owned <= out_valid;
          end else begin
            tx_sr <= {tx_sr[6:0], 1'b1};
          end
        end
      end
    end
  end

  // R11
  pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> out_valid);
  // R11
  pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |=> !out_ready);
endmodule

// File: rtl/spi_ff_filter.sv
module spi_ff_filter
  import spi_stream_pkg::*;
#(
  parameter int RUN_LIMIT = 50
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  byte_valid,
  input  byte_t byte_in,
  output logic  fwd_valid,
  output byte_t fwd_byte
);
  localparam int RUN_W = $clog2(RUN_LIMIT + 1);
  localparam logic [RUN_W-1:0] LIMIT = RUN_W'(RUN_LIMIT);

  logic [RUN_W-1:0] run_q;
  logic             is_fill;
  assign is_fill = (byte_in == FILL_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      fwd_valid <= 1'b0;
      fwd_byte  <= '0;
    end else begin
      fwd_valid <= 1'b0;
      if (byte_valid) begin
        if (!is_fill) begin
          run_q     <= '0;
          fwd_valid <= 1'b1;
          fwd_byte  <= byte_in;
        end else if (run_q != LIMIT) begin
          run_q     <= run_q + 1'b1;
          fwd_valid <= 1'b1;
          fwd_byte  <= byte_in;
        end
      end
    end
  end

  // R7
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIMIT);
  // R7
  fill_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && is_fill && run_q == LIMIT) |=> !fwd_valid);
endmodule

// File: rtl/spi_stream_port.sv
module spi_stream_port
  import spi_stream_pkg::*;
#(
  parameter int RUN_LIMIT = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_mosi,
  input  logic       spi_cs_n,
  output logic       spi_miso,
  input  logic       out_valid,
  input  logic [7:0] out_data,
  output logic       out_ready,
  output logic       in_valid,
  output logic [7:0] in_data,
  input  logic       in_ready
);
  logic [2:0] pins_s;
  logic       rx_valid, fwd_valid;
  byte_t      rx_byte, fwd_byte;

  spi_pin_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({spi_cs_n, spi_mosi, spi_sclk}),
    .sync_o(pins_s)
  );

  spi_byte_engine #(.BYTE_W(8)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[0]), .mosi_s(pins_s[1]), .cs_n_s(pins_s[2]),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .miso(spi_miso), .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  spi_ff_filter #(.RUN_LIMIT(RUN_LIMIT)) u_filter (
    .clk(clk), .rst_n(rst_n),
    .byte_valid(rx_valid), .byte_in(rx_byte),
    .fwd_valid(fwd_valid), .fwd_byte(fwd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_valid <= 1'b0;
      in_data  <= '0;
    end else if (fwd_valid && (!in_valid || in_ready)) begin
      in_valid <= 1'b1;
      in_data  <= fwd_byte;
    end else if (in_ready) begin
      in_valid <= 1'b0;
    end
  end

  // R10
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_data)));
endmodule

// File: tb/spi_stream_port_bench.sv
module spi_stream_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 105;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, mosi = 1, cs_n = 1;
  logic miso, out_ready, in_valid, in_ready = 1;
  logic [7:0] out_data, in_data;
  logic out_valid;

  logic [7:0] oq [0:15];
  logic [3:0] oq_rd = 0, oq_wr = 0;
  logic [7:0] il [0:127];
  int il_n = 0;
  int pops = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  assign out_valid = (oq_rd != oq_wr);
  assign out_data  = oq[oq_rd];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_stream_port u_spi_stream_port (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_cs_n(cs_n), .spi_miso(miso), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready)
  );

  always @(posedge clk) begin
    if (out_ready && out_valid) begin
      oq_rd <= oq_rd + 1'b1;
      pops  <= pops + 1;
    end
    if (in_valid && in_ready) begin
      il[il_n[6:0]] <= in_data;
      il_n <= il_n + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    oq[oq_wr] = b;
    oq_wr = oq_wr + 1'b1;
  endtask

  task automatic cs_begin();
    cs_n = 0;
    #(HALF);
  endtask

  task automatic cs_end();
    #(HALF);
    cs_n = 1;
    #(HALF * 2);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      #(HALF);
      rx[i] = miso;
      sclk = 1;
      #(HALF);
      sclk = 0;
    end
    mosi = 1;
  endtask

  task automatic t_reset();
    check("R1 miso", miso, 1);
    check("R1 in_valid", in_valid, 0);
    check("R1 out_ready", out_ready, 0);
  endtask

  task automatic t_basic();
    logic [7:0] r0, r1;
    int n0 = il_n, p0 = pops;
    push(8'hA5); push(8'h3C);
    cs_begin();
    xfer(8'h5A, r0);
    xfer(8'hC3, r1);
    cs_end();
    check("R3 miso byte0", r0, 8'hA5);
    check("R3 miso byte1", r1, 8'h3C);
    check("R2 count", il_n - n0, 2);
    check("R2 byte0", il[n0], 8'h5A);
    check("R2 byte1", il[n0 + 1], 8'hC3);
    check("R11 pops", pops - p0, 2);
  endtask

  task automatic t_empty();
    logic [7:0] r;
    int n0 = il_n, p0 = pops;
    cs_begin();
    xfer(8'h12, r);
    cs_end();
    check("R4 fill", r, 8'hFF);
    check("R4 no pop", pops - p0, 0);
    check("R2 empty rx", il[n0], 8'h12);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    int n0 = il_n;
    push(8'h77);
    cs_begin();
    for (int i = 0; i < 3; i++) begin
      mosi = 0; #(HALF); sclk = 1; #(HALF); sclk = 0;
    end
    #(HALF);
    cs_n = 1;
    #(HALF);
    check("R5 miso idle", miso, 1);
    #(HALF);
    check("R5 partial dropped", il_n - n0, 0);
    push(8'h88);
    cs_begin();
    xfer(8'h01, r);
    cs_end();
    check("R6 popped byte lost", r, 8'h88);
    check("R5 clean realign", il[n0], 8'h01);
    push(8'h99);
    cs_begin();
    cs_end();
    cs_begin();
    xfer(8'h02, r);
    cs_end();
    check("R6 unpopped kept", r, 8'h99);
  endtask

  task automatic t_filter();
    logic [7:0] r;
    int n0 = il_n;
    cs_begin();
    for (int i = 0; i < 50; i++) xfer(8'hFF, r);
    cs_end();
    check("R7 first 50 kept", il_n - n0, 50);
    check("R7 last kept", il[n0 + 49], 8'hFF);
    cs_begin();
    xfer(8'hFF, r);
    xfer(8'hFF, r);
    cs_end();
    check("R9 count kept across CS", il_n - n0, 50);
    cs_begin();
    xfer(8'h42, r);
    xfer(8'hFF, r);
    cs_end();
    check("R8 resume count", il_n - n0, 52);
    check("R8 resume byte", il[n0 + 50], 8'h42);
    check("R8 fill after resume", il[n0 + 51], 8'hFF);
  endtask

  task automatic t_backpressure();
    logic [7:0] r;
    int n0 = il_n;
    in_ready = 0;
    cs_begin();
    xfer(8'h11, r);
    xfer(8'h22, r);
    cs_end();
    check("R10 held valid", in_valid, 1);
    check("R10 held data", in_data, 8'h11);
    in_ready = 1;
    #(CLK_PERIOD * 10);
    check("R10 one accepted", il_n - n0, 1);
    check("R10 accepted byte", il[n0], 8'h11);
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 3);
    t_reset();
    rst_n = 1;
    #(CLK_PERIOD * 5);
    t_basic();
    t_empty();
    t_abort();
    t_filter();
    t_backpressure();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule